// File: doc/BRIEF.md
# Triggered Transaction Trace Buffer

This block records transactions from one of several internal dispatch interfaces into a 256-entry, 64-bit on-chip store. It is used for post-mortem debug. Software writes one control word. That word picks the interface to watch and the qualifier that decides which cycles are recorded. It also picks whether recording starts at once or waits for an external watchpoint event, and whether recording ends on an event or when the store fills. After recording ends, software reads the captured entries back through an index port.

The block also contains a comparator that checks the selected interface's transaction type, source and target against programmed values. Each of the three comparisons has its own enable. The comparator result is reported on a registered `hit` output. A monitor-only setting turns off every recording option, so the block serves purely as a second watchpoint comparator.

The store depth must be a power of two.

Top module: `txn_trace_buffer`

## Requirements
- R1: After synchronous reset, `armed`, `running`, `full`, `wrapped` and `hit` are low, `count` is 0, and `cfg_rdata` is 0.
- R2: A write of the control word has these effects on the next edge:
  - It clears the write pointer, `wrapped` and `full`.
  - It stores the word with bits [31:24] forced to zero. `cfg_rdata` returns the stored word.
  - If bit 23 (start on event) is 0 and bit 3 is 0, `running` rises.
  - If bit 23 is 1 and bit 3 is 0, `armed` rises. `armed` then holds with nothing recorded until `wp_event` is high, and the following edge moves the block to `running`.
- R3: Bits [5:4] select interface index 0, 1 or 2; the value 3 selects no interface. With qualifier bits [1:0] = 0, every cycle in which the selected interface is valid while running writes one entry. Transactions on the other interfaces are never recorded.
- R4: With qualifier bits [1:0] = 1, an entry is written only in a cycle where the selected interface is valid and `wp_event` is high in that same cycle.
- R5: With qualifier bits [1:0] = 2, an entry is written only in a cycle where the comparator matches (see R10).
- R6: Each entry holds these fields, with bits [31:19] written as zero:

  | Bits | Field |
  |------|-------|
  | [4:0] | transaction type |
  | [9:5] | source ID |
  | [13:10] | target ID |
  | [18:14] | byte count |
  | [63:32] | address |
- R7: With bit 2 = 0 (stop on event), the write pointer wraps after entry 255 and `wrapped` rises. A `wp_event` while running ends recording after that cycle's capture.
- R8: With bit 2 = 1 (stop when full), the 256th write sets `full` and clears `running`, and later transactions are not recorded.
- R9: With bit 3 = 1 (monitor only), nothing is recorded, and `running` and `armed` stay low.
- R10: `hit` goes high one cycle after a cycle in which the selected interface is valid and every enabled comparison is true. The enables are: bit 6 for type against bits [13:9], bit 7 for source against bits [18:14], and bit 8 for target against bits [22:19].
- R11: `rd_data` presents the entry at `rd_idx` one cycle after `rd_idx` is applied.
- R12: `count` equals the number of entries written since the last control write, saturating at 256 once `full` or `wrapped` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_valid | input | NUM_IF | Per-interface transaction valid strobe |
| if_type | input | NUM_IF*5 | Per-interface transaction type, interface i at [5i+4:5i] |
| if_src | input | NUM_IF*5 | Per-interface source ID |
| if_tgt | input | NUM_IF*4 | Per-interface target ID |
| if_bytes | input | NUM_IF*5 | Per-interface byte count |
| if_addr | input | NUM_IF*32 | Per-interface address |
| wp_event | input | 1 | External watchpoint event |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Stored control word |
| rd_idx | input | 8 | Entry index to read |
| rd_data | output | 64 | Entry read data, one cycle after `rd_idx` |
| armed | output | 1 | Waiting for the start event |
| running | output | 1 | Recording active |
| full | output | 1 | Store filled in stop-when-full setting |
| wrapped | output | 1 | Write pointer has wrapped at least once |
| count | output | 9 | Number of valid entries |
| hit | output | 1 | Registered comparator match |

## Verification
The assertions assume the following about the inputs:
- A control write takes precedence in its cycle and records nothing.
- `rd_idx` changes only between edges.
- The interface select never names an index beyond the instantiated interfaces, except the reserved value 3, which must select nothing.

The stimulus changes every input at the falling edge. It narrows the random type, source and target values to a few codes so that qualifier-2 and monitor runs produce a mix of matches and misses. It reads entries only while no capture is under way, so read-before-write ordering never decides an expected value.

// File: rtl/trc_pkg.sv
`timescale 1ns/100ps
package trc_pkg;

    localparam int TT_W    = 5;
    localparam int SID_W   = 5;
    localparam int TID_W   = 4;
    localparam int BC_W    = 5;
    localparam int ADDR_W  = 32;
    localparam int ENTRY_W = 64;
    localparam int CFG_W   = 32;
    localparam int SEL_W   = 2;
    localparam int ATTR_W  = TT_W + SID_W + TID_W + BC_W;
    localparam int PAD_W   = ENTRY_W - ADDR_W - ATTR_W;
    localparam int RSVD_W  = CFG_W - 2 - 1 - 1 - SEL_W - 3 - TT_W - SID_W - TID_W - 1;

    typedef enum logic [1:0] {
        QUAL_EVERY = 2'd0,
        QUAL_WPEVT = 2'd1,
        QUAL_MATCH = 2'd2,
        QUAL_OFF   = 2'd3
    } qual_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } tstate_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BC_W-1:0]   bytes;
        logic [TID_W-1:0]  tgt;
        logic [SID_W-1:0]  src;
        logic [TT_W-1:0]   ttype;
    } txn_t;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic              start_on_evt;
        logic [TID_W-1:0]  tgt_val;
        logic [SID_W-1:0]  src_val;
        logic [TT_W-1:0]   tt_val;
        logic              tgt_en;
        logic              src_en;
        logic              tt_en;
        logic [SEL_W-1:0]  if_sel;
        logic              mon_only;
        logic              stop_full;
        qual_e             qual;
    } ctl_t;

    function automatic logic [ENTRY_W-1:0] pack_entry(input txn_t t);
        return {t.addr, {PAD_W{1'b0}}, t.bytes, t.tgt, t.src, t.ttype};
    endfunction

    function automatic ctl_t decode_ctl(input logic [CFG_W-1:0] w);
        ctl_t c;
        c      = ctl_t'(w);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/trc_if_mux.sv
`timescale 1ns/100ps
module trc_if_mux
    import trc_pkg::*;
#(
    parameter int NUM_IF = 3
) (
    input  logic [NUM_IF-1:0]        if_valid,
    input  logic [NUM_IF*TT_W-1:0]   if_type,
    input  logic [NUM_IF*SID_W-1:0]  if_src,
    input  logic [NUM_IF*TID_W-1:0]  if_tgt,
    input  logic [NUM_IF*BC_W-1:0]   if_bytes,
    input  logic [NUM_IF*ADDR_W-1:0] if_addr,
    input  logic [SEL_W-1:0]         if_sel,
    output logic                     sel_valid,
    output txn_t                     sel_txn
);

    txn_t lane [NUM_IF];

    generate
        for (genvar g = 0; g < NUM_IF; g++) begin : g_lane
            assign lane[g].ttype = if_type [g*TT_W   +: TT_W];
            assign lane[g].src   = if_src  [g*SID_W  +: SID_W];
            assign lane[g].tgt   = if_tgt  [g*TID_W  +: TID_W];
            assign lane[g].bytes = if_bytes[g*BC_W   +: BC_W];
            assign lane[g].addr  = if_addr [g*ADDR_W +: ADDR_W];
        end
    endgenerate

    always_comb begin
        sel_valid = 1'b0;
        sel_txn   = '0;
        for (int i = 0; i < NUM_IF; i++) begin
            if (if_sel == SEL_W'(i)) begin
                sel_valid = if_valid[i];
                sel_txn   = lane[i];
            end
        end
    end

endmodule

// File: rtl/trc_matcher.sv
`timescale 1ns/100ps
module trc_matcher
    import trc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_valid,
    input  logic [TT_W-1:0]  in_type,
    input  logic [SID_W-1:0] in_src,
    input  logic [TID_W-1:0] in_tgt,
    input  logic             tt_en,
    input  logic             src_en,
    input  logic             tgt_en,
    input  logic [TT_W-1:0]  tt_val,
    input  logic [SID_W-1:0] src_val,
    input  logic [TID_W-1:0] tgt_val,
    output logic             match,
    output logic             hit
);

    logic tt_ok, src_ok, tgt_ok;

    assign tt_ok  = !tt_en  || (in_type == tt_val);
    assign src_ok = !src_en || (in_src  == src_val);
    assign tgt_ok = !tgt_en || (in_tgt  == tgt_val);
    assign match  = sel_valid && tt_ok && src_ok && tgt_ok;

    always_ff @(posedge clk) begin
        if (rst) hit <= 1'b0;
        else     hit <= match;
    end

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(sel_valid)) else $error("hit without valid"); // R10

endmodule

// File: rtl/trc_ctrl.sv
`timescale 1ns/100ps
module trc_ctrl
    import trc_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             new_mon_only,
    input  logic             new_start_evt,
    input  qual_e            qual,
    input  logic             stop_full,
    input  logic             sel_valid,
    input  logic             match,
    input  logic             wp_event,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_ptr,
    output logic             armed,
    output logic             running,
    output logic             full,
    output logic             wrapped,
    output logic [CNT_W-1:0] count
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    tstate_e state;
    logic    qualify;

    always_comb begin
        unique case (qual)
            QUAL_EVERY: qualify = sel_valid;
            QUAL_WPEVT: qualify = sel_valid && wp_event;
            QUAL_MATCH: qualify = match;
            default:    qualify = 1'b0;
        endcase
    end

    assign running = (state == ST_RUN);
    assign armed   = (state == ST_ARMED);
    assign wr_en   = running && qualify && !cfg_we;
    assign count   = (full || wrapped) ? CNT_W'(DEPTH) : {1'b0, wr_ptr};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            wr_ptr  <= '0;
            full    <= 1'b0;
            wrapped <= 1'b0;
        end else if (cfg_we) begin
            wr_ptr  <= '0;
            full    <= 1'b0;
            wrapped <= 1'b0;
            if (new_mon_only)       state <= ST_IDLE;
            else if (new_start_evt) state <= ST_ARMED;
            else                    state <= ST_RUN;
        end else begin
            case (state)
                ST_ARMED: begin
                    if (wp_event) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (wr_en) begin
                        wr_ptr <= wr_ptr + 1'b1;
                        if (wr_ptr == LAST) begin
                            if (stop_full) begin
                                full  <= 1'b1;
                                state <= ST_DONE;
                            end else begin
                                wrapped <= 1'b1;
                            end
                        end
                    end
                    if (!stop_full && wp_event) state <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (wr_ptr == '0 && !full && !wrapped)) else $error("cfg clear"); // R2
    AST_ARMED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        armed |-> !wr_en) else $error("write while armed"); // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wr_ptr == $past(wr_ptr) + 1'b1) else $error("ptr step"); // R12
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !cfg_we) |=> $stable(wr_ptr)) else $error("ptr moved"); // R3
    AST_FULL_HALTS: assert property (@(posedge clk) disable iff (rst)
        full |-> !running) else $error("running when full"); // R8
    AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        $rose(wrapped) |-> wr_ptr == '0) else $error("wrap position"); // R7

endmodule

// File: rtl/trc_store.sv
`timescale 1ns/100ps
module trc_store #(
    parameter  int DEPTH = 256,
    parameter  int WIDTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/txn_trace_buffer.sv
`timescale 1ns/100ps
module txn_trace_buffer
    import trc_pkg::*;
#(
    parameter  int NUM_IF = 3,
    parameter  int DEPTH  = 256,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_IF-1:0]        if_valid,
    input  logic [NUM_IF*TT_W-1:0]   if_type,
    input  logic [NUM_IF*SID_W-1:0]  if_src,
    input  logic [NUM_IF*TID_W-1:0]  if_tgt,
    input  logic [NUM_IF*BC_W-1:0]   if_bytes,
    input  logic [NUM_IF*ADDR_W-1:0] if_addr,
    input  logic                     wp_event,
    input  logic                     cfg_we,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [CFG_W-1:0]         cfg_rdata,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [ENTRY_W-1:0]       rd_data,
    output logic                     armed,
    output logic                     running,
    output logic                     full,
    output logic                     wrapped,
    output logic [IDX_W:0]           count,
    output logic                     hit
);

    ctl_t             ctl_q;
    ctl_t             ctl_new;
    logic             sel_valid;
    txn_t             sel_txn;
    logic             match;
    logic             wr_en;
    logic [IDX_W-1:0] wr_ptr;

    assign ctl_new   = decode_ctl(cfg_wdata);
    assign cfg_rdata = ctl_q;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (cfg_we) ctl_q <= ctl_new;
    end

    trc_if_mux #(.NUM_IF(NUM_IF)) u_mux (
        .if_valid (if_valid),
        .if_type  (if_type),
        .if_src   (if_src),
        .if_tgt   (if_tgt),
        .if_bytes (if_bytes),
        .if_addr  (if_addr),
        .if_sel   (ctl_q.if_sel),
        .sel_valid(sel_valid),
        .sel_txn  (sel_txn)
    );

    trc_matcher u_match (
        .clk      (clk),
        .rst      (rst),
        .sel_valid(sel_valid),
        .in_type  (sel_txn.ttype),
        .in_src   (sel_txn.src),
        .in_tgt   (sel_txn.tgt),
        .tt_en    (ctl_q.tt_en),
        .src_en   (ctl_q.src_en),
        .tgt_en   (ctl_q.tgt_en),
        .tt_val   (ctl_q.tt_val),
        .src_val  (ctl_q.src_val),
        .tgt_val  (ctl_q.tgt_val),
        .match    (match),
        .hit      (hit)
    );

    trc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_we       (cfg_we),
        .new_mon_only (ctl_new.mon_only),
        .new_start_evt(ctl_new.start_on_evt),
        .qual         (ctl_q.qual),
        .stop_full    (ctl_q.stop_full),
        .sel_valid    (sel_valid),
        .match        (match),
        .wp_event     (wp_event),
        .wr_en        (wr_en),
        .wr_ptr       (wr_ptr),
        .armed        (armed),
        .running      (running),
        .full         (full),
        .wrapped      (wrapped),
        .count        (count)
    );

    trc_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_ptr),
        .wr_data(pack_entry(sel_txn)),
        .rd_addr(rd_idx),
        .rd_data(rd_data)
    );

    AST_MON_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ctl_q.mon_only |-> !wr_en) else $error("capture in monitor mode"); // R9
    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[CFG_W-1:CFG_W-RSVD_W] == '0) else $error("reserved bits"); // R2

endmodule

// File: tb/tb_txn_trace_buffer.sv
`timescale 1ns/100ps
module tb_txn_trace_buffer;

    localparam int NIF = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    if_valid = '0;
    logic [14:0]   if_type = '0;
    logic [14:0]   if_src = '0;
    logic [11:0]   if_tgt = '0;
    logic [14:0]   if_bytes = '0;
    logic [95:0]   if_addr = '0;
    logic          wp_event = 1'b0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [7:0]    rd_idx = '0;
    logic [63:0]   rd_data;
    logic          armed, running, full, wrapped, hit;
    logic [8:0]    count;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    txn_trace_buffer dut (
        .clk(clk), .rst(rst), .if_valid(if_valid), .if_type(if_type), .if_src(if_src),
        .if_tgt(if_tgt), .if_bytes(if_bytes), .if_addr(if_addr), .wp_event(wp_event),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_idx(rd_idx),
        .rd_data(rd_data), .armed(armed), .running(running), .full(full),
        .wrapped(wrapped), .count(count), .hit(hit)
    );

    // reference model state
    int          m_state;   // 0 idle, 1 waiting, 2 recording, 3 stopped
    int          m_ptr;
    bit          m_wrap, m_full, m_hit, m_rd_ok;
    logic [31:0] m_cfg;
    logic [63:0] m_mem [256];
    bit          m_written [256];
    logic [63:0] m_rd;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int qual, input bit stopf, input bit mon,
            input int sel, input bit tte, input bit srce, input bit tgte,
            input int ttv, input int srcv, input int tgtv, input bit startev);
        logic [31:0] w;
        w = '0;
        w[1:0]   = 2'(qual);
        w[2]     = stopf;
        w[3]     = mon;
        w[5:4]   = 2'(sel);
        w[6]     = tte;
        w[7]     = srce;
        w[8]     = tgte;
        w[13:9]  = 5'(ttv);
        w[18:14] = 5'(srcv);
        w[22:19] = 4'(tgtv);
        w[23]    = startev;
        return w;
    endfunction

    task automatic model_step();
        int   s;
        bit   sv, mt, q;
        logic [4:0] tt, sr, bc;
        logic [3:0] tg;
        logic [31:0] ad;
        if (rst) begin
            m_state = 0; m_ptr = 0; m_wrap = 0; m_full = 0; m_hit = 0;
            m_cfg = '0; m_rd_ok = 0;
            return;
        end
        s  = int'(m_cfg[5:4]);
        sv = 0; tt = '0; sr = '0; bc = '0; tg = '0; ad = '0;
        if (s < NIF) begin
            sv = if_valid[s];
            tt = if_type[s*5 +: 5];
            sr = if_src[s*5 +: 5];
            tg = if_tgt[s*4 +: 4];
            bc = if_bytes[s*5 +: 5];
            ad = if_addr[s*32 +: 32];
        end
        mt = sv && (!m_cfg[6] || tt == m_cfg[13:9]) && (!m_cfg[7] || sr == m_cfg[18:14])
                && (!m_cfg[8] || tg == m_cfg[22:19]);
        m_rd    = m_mem[rd_idx];
        m_rd_ok = m_written[rd_idx];
        m_hit   = mt;
        if (cfg_we) begin
            m_cfg  = cfg_wdata & 32'h00FF_FFFF;
            m_ptr  = 0; m_wrap = 0; m_full = 0;
            m_state = cfg_wdata[3] ? 0 : (cfg_wdata[23] ? 1 : 2);
        end else if (m_state == 1) begin
            if (wp_event) m_state = 2;
        end else if (m_state == 2) begin
            case (m_cfg[1:0])
                2'd0: q = sv;
                2'd1: q = sv && wp_event;
                2'd2: q = mt;
                default: q = 0;
            endcase
            if (q) begin
                m_mem[m_ptr]     = {ad, 13'b0, bc, tg, sr, tt};
                m_written[m_ptr] = 1;
                if (m_ptr == 255) begin
                    if (m_cfg[2]) begin m_full = 1; m_state = 3; end
                    else m_wrap = 1;
                end
                m_ptr = (m_ptr + 1) % 256;
            end
            if (!m_cfg[2] && wp_event) m_state = 3;
        end
    endtask

    task automatic compare();
        int ec;
        ec = (m_full || m_wrap) ? 256 : m_ptr;
        chk(armed == (m_state == 1), "R2", "armed", 64'(armed), 64'(m_state == 1));
        chk(running == (m_state == 2), "R2", "running", 64'(running), 64'(m_state == 2));
        chk(full == m_full, "R8", "full", 64'(full), 64'(m_full));
        chk(wrapped == m_wrap, "R7", "wrapped", 64'(wrapped), 64'(m_wrap));
        chk(int'(count) == ec, "R12", "count", 64'(count), 64'(ec));
        chk(hit == m_hit, "R10", "hit", 64'(hit), 64'(m_hit));
        chk(cfg_rdata == m_cfg, "R2", "cfg_rdata", 64'(cfg_rdata), 64'(m_cfg));
        if (m_rd_ok)
            chk(rd_data == m_rd, "R11", "rd_data", rd_data, m_rd);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic write_cfg(input logic [31:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic set_lanes(input int tmod, input int vmod);
        for (int g = 0; g < NIF; g++) begin
            if_valid[g]          = ($urandom % vmod) != 0;
            if_type[g*5 +: 5]    = 5'($urandom % tmod);
            if_src[g*5 +: 5]     = 5'($urandom % tmod);
            if_tgt[g*4 +: 4]     = 4'($urandom % tmod);
            if_bytes[g*5 +: 5]   = 5'($urandom);
            if_addr[g*32 +: 32]  = $urandom;
        end
    endtask

    task automatic quiet();
        if_valid = '0; wp_event = 1'b0;
    endtask

    task automatic read_all(input int n);
        for (int i = 0; i < n; i++) begin
            rd_idx = 8'(i);
            tick();
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) m_written[i] = 0;

        // R1 reset state
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(!armed && !running && !full && !wrapped && !hit, "R1", "flags", 64'({armed, running, full, wrapped, hit}), 64'(0));
        chk(count == 0 && cfg_rdata == 0, "R1", "count/cfg", 64'(count), 64'(0));

        // R6 entry format
        write_cfg(mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0) | 32'hFF00_0000);
        chk(cfg_rdata[31:24] == 0, "R2", "reserved readback", 64'(cfg_rdata), 64'(0));
        if_valid = 3'b001;
        if_type[4:0] = 5'h15; if_src[4:0] = 5'h0A; if_tgt[3:0] = 4'h9;
        if_bytes[4:0] = 5'h1F; if_addr[31:0] = 32'hDEADBEEF;
        tick();
        quiet(); wp_event = 1'b1;
        tick();
        wp_event = 1'b0;
        rd_idx = 8'd0;
        tick();
        chk(rd_data == 64'hDEADBEEF_0007_E55 >> 0 || 1'b0 ? 1'b0 : rd_data == {32'hDEADBEEF, 13'b0, 5'h1F, 4'h9, 5'h0A, 5'h15},
            "R6", "entry layout", rd_data, {32'hDEADBEEF, 13'b0, 5'h1F, 4'h9, 5'h0A, 5'h15});
        chk(count == 1 && !running, "R7", "stop on event", 64'(count), 64'(1));

        // R3 every-valid qualifier on interface 1
        write_cfg(mk_cfg(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
        n = 0;
        for (int c = 0; c < 40; c++) begin
            set_lanes(32, 3);
            if (if_valid[1]) n++;
            tick();
        end
        quiet(); wp_event = 1'b1; tick(); wp_event = 1'b0;
        chk(int'(count) == n, "R3", "lane 1 captures", 64'(count), 64'(n));
        read_all(n);

        // R4 event qualifier on interface 0
        write_cfg(mk_cfg(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        n = 0;
        for (int c = 0; c < 40; c++) begin
            set_lanes(32, 2);
            wp_event = ($urandom % 2) != 0;
            if (if_valid[0] && wp_event) n++;
            tick();
        end
        quiet(); tick();
        chk(int'(count) == n, "R4", "event-qualified captures", 64'(count), 64'(n));
        read_all(n);

        // R5 match qualifier on interface 2
        write_cfg(mk_cfg(2, 1, 0, 2, 1, 1, 0, 2, 1, 0, 0));
        n = 0;
        for (int c = 0; c < 80; c++) begin
            set_lanes(4, 4);
            if (if_valid[2] && if_type[14:10] == 5'd2 && if_src[14:10] == 5'd1) n++;
            tick();
        end
        quiet(); tick();
        chk(int'(count) == n, "R5", "match-qualified captures", 64'(count), 64'(n));
        read_all(n);

        // R2 start on event
        write_cfg(mk_cfg(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        if_valid = 3'b111;
        repeat (5) tick();
        chk(armed && count == 0, "R2", "armed holds", 64'(count), 64'(0));
        wp_event = 1'b1; tick(); wp_event = 1'b0;
        chk(running, "R2", "running after event", 64'(running), 64'(1));
        repeat (3) tick();
        chk(count == 3, "R2", "captures after start", 64'(count), 64'(3));

        // R8 stop when full
        write_cfg(mk_cfg(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        for (int c = 0; c < 270; c++) begin
            set_lanes(32, 1000000);
            if_valid = 3'b111;
            tick();
        end
        quiet(); tick();
        chk(full && !running && count == 256, "R8", "full stop", 64'(count), 64'(256));

        // R7 wrap in stop-on-event setting
        write_cfg(mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        for (int c = 0; c < 300; c++) begin
            set_lanes(32, 1000000);
            if_valid = 3'b001;
            tick();
        end
        chk(wrapped && running && count == 256, "R7", "wrapped", 64'(count), 64'(256));
        quiet(); wp_event = 1'b1; tick(); wp_event = 1'b0;
        chk(!running, "R7", "event ends recording", 64'(running), 64'(0));
        read_all(256);

        // R9 monitor only, target compare on interface 1
        write_cfg(mk_cfg(0, 0, 1, 1, 0, 0, 1, 0, 0, 3, 0));
        n = 0;
        begin
            int seen;
            seen = 0;
            for (int c = 0; c < 60; c++) begin
                set_lanes(4, 3);
                wp_event = ($urandom % 5) == 0;
                if (if_valid[1] && if_tgt[7:4] == 4'd3) n++;
                tick();
                if (hit) seen++;
            end
            chk(seen == n && n > 0, "R9", "monitor hits", 64'(seen), 64'(n));
        end
        quiet(); tick();
        chk(count == 0 && !running && !armed, "R9", "no capture", 64'(count), 64'(0));

        // R3 reserved select value captures nothing
        write_cfg(mk_cfg(0, 1, 0, 3, 0, 0, 0, 0, 0, 0, 0));
        for (int c = 0; c < 20; c++) begin
            set_lanes(32, 1000000);
            if_valid = 3'b111;
            tick();
        end
        chk(count == 0, "R3", "select 3 idle", 64'(count), 64'(0));

        quiet(); tick();
        finish_run();
    end

endmodule